// File: doc/BRIEF.md
# Zero-Overhead Loop Instruction Cache

This block sits between the fetch unit and the decoder and runs short loops without branch cost. A loop is armed with a body length (1 to 31 instructions), a pass count and the opcode of the instruction that comes after the loop. On the first pass the block asks the fetch unit for the body. Each fetched instruction goes straight through to the decoder and is also stored in an internal entry, together with a flag that marks it as 16 or 32 bits wide. The remaining passes are issued from the stored entries, and program memory is not touched. After the last pass the block issues the saved follow-on opcode once and returns to idle. A start request is taken only while the block is idle.

An interrupt handler stops the block with a hold input. It can then read and rewrite the pass counter, the state word and the follow-on opcode through a small register port, and read or rewrite every entry through an address window. When the handler restores these values and releases hold, replay continues at the exact instruction where it stopped.

Top module: `zol_cache`

## Requirements
- R1: After reset the block is idle. `fetchReq`, `issueValid`, `issueFollow` and `errFlag` are 0, and the count and state registers read 0.
- R2: After an accepted start the block is in the capture phase. `fetchReq` is 1 while hold is low. Each cycle with `fetchValid` high, the fetched word and its width flag appear on the issue outputs in the same cycle, and they are stored in the next entry.
- R3: When capture ends with more than one pass, the stored body is issued again for count−1 passes, one entry per cycle, in order and with each width flag. `fetchReq` stays 0 during replay.
- R4: After the last pass the saved follow-on opcode is issued for exactly one cycle, with `issueFollow`=1 and `issueIs32`=1. The block is idle in the cycle after that.
- R5: A count of 0 or 1 issues the body once, from capture only, and then issues the follow-on opcode.
- R6: A start with length 0 or greater than 31 sets `errFlag` and leaves the block idle with nothing fetched. The next valid start clears `errFlag`.
- R7: While `hold` is 1, nothing is issued and nothing is fetched. The replay index, the pass count and the phase keep their values.
- R8: The register port selects with `regSel`: 0 is the count, 1 is the state, 2 is the follow-on opcode. The state word is laid out as follows: bits [1:0] hold the phase (0 idle, 1 capture, 2 replay, 3 follow-on), bits [6:2] hold the next entry index, and bits [11:7] hold the body length. A write takes effect at the next clock and overrides stepping, so a written state resumes exactly.
- R9: The window at `memAddr` reads entry contents combinationally and writes them at the clock. Bit 32 of an entry is the 32-bit flag and bits [31:0] are the opcode.
- R10: The count register holds the number of passes still to run, including the current pass. It is loaded with max(count,1) at start and decrements at the end of each pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loopStart | input | 1 | Arm a loop (taken when idle) |
| reqLen | input | 6 | Body length in instructions |
| reqCount | input | 16 | Pass count |
| reqFollow | input | 32 | Opcode following the loop |
| fetchValid | input | 1 | Fetched instruction present |
| fetchInstr | input | 32 | Fetched instruction |
| fetchIs32 | input | 1 | Fetched instruction is 32 bits wide |
| fetchReq | output | 1 | Request for program-memory fetch |
| hold | input | 1 | Freeze for interrupt entry |
| issueValid | output | 1 | Instruction presented to decoder |
| issueInstr | output | 32 | Instruction to decoder |
| issueIs32 | output | 1 | Issued instruction is 32 bits wide |
| issueFollow | output | 1 | Issued word is the follow-on opcode |
| errFlag | output | 1 | Last start had an illegal length |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data |
| memWe | input | 1 | Entry window write strobe |
| memAddr | input | 5 | Entry index |
| memWdata | input | 33 | Entry write data (flag, opcode) |
| memRdata | output | 33 | Entry read data (flag, opcode) |

## Verification
The bench runs several loop shapes: a one-instruction body, count 0, count 1, the full 31-entry body, and mixed 16/32-bit bodies. A design that miscounts passes would issue one pass too many or too few, or skip the follow-on opcode. A design that drops the width flag would replay 32-bit words as 16-bit ones. Illegal lengths 0 and 32 must leave the block idle with the error flag set; a wrong length check would start a capture and raise `fetchReq`. The bench also stops a replay in mid-pass, clobbers the state, the count and an entry, and restores them. A design that did not honour the written state, or that moved on while held, would resume at the wrong instruction.

// File: rtl/zol_cache_pkg.sv
package zol_cache_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CAPT   = 2'd1,
    PH_REPLAY = 2'd2,
    PH_FOLLOW = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_FETCH  = 2'd1,
    SRC_ENTRY  = 2'd2,
    SRC_FOLLOW = 2'd3
  } issue_src_e;

  typedef struct packed {
    logic       capWr;
    issue_src_e src;
  } strobe_t;

  localparam logic [1:0] SEL_COUNT  = 2'd0;
  localparam logic [1:0] SEL_STATE  = 2'd1;
  localparam logic [1:0] SEL_FOLLOW = 2'd2;
endpackage

// File: rtl/zol_cache_ctrl.sv
module zol_cache_ctrl
  import zol_cache_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int IW    = 32,
  parameter int CW    = 16,
  localparam int IDX_W = $clog2(DEPTH + 1),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loopStart,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [CW-1:0]    reqCount,
  input  logic [IW-1:0]    reqFollow,
  input  logic             fetchValid,
  input  logic             hold,
  input  logic             regWe,
  input  logic [1:0]       regSel,
  input  logic [IW-1:0]    regWdata,
  output logic [IW-1:0]    regRdata,
  output logic             fetchReq,
  output logic             errFlag,
  output strobe_t          stb,
  output logic [IDX_W-1:0] idx,
  output logic [IW-1:0]    followOp,
  output phase_e           phase
);
  localparam logic [LEN_W-1:0] MAXLEN = LEN_W'(DEPTH);
  localparam int ST_IDX = 2;
  localparam int ST_LEN = 2 + IDX_W;

  logic [IDX_W-1:0] lenReg;
  logic [CW-1:0]    cnt;
  logic             step, passEnd, badLen, startOk;

  assign badLen  = (reqLen == '0) || (reqLen > MAXLEN);
  assign startOk = loopStart && (phase == PH_IDLE);
  assign step    = !hold && (((phase == PH_CAPT) && fetchValid) || (phase == PH_REPLAY));
  assign passEnd = step && (idx == lenReg - IDX_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      idx      <= '0;
      lenReg   <= '0;
      cnt      <= '0;
      followOp <= '0;
      errFlag  <= 1'b0;
    end else if (regWe) begin
      case (regSel)
        SEL_COUNT:  cnt <= regWdata[CW-1:0];
        SEL_STATE: begin
          phase  <= phase_e'(regWdata[1:0]);
          idx    <= regWdata[ST_IDX +: IDX_W];
          lenReg <= regWdata[ST_LEN +: IDX_W];
        end
        SEL_FOLLOW: followOp <= regWdata;
        default: ;
      endcase
    end else if (startOk) begin
      if (badLen) begin
        errFlag <= 1'b1;
      end else begin
        errFlag  <= 1'b0;
        phase    <= PH_CAPT;
        idx      <= '0;
        lenReg   <= reqLen[IDX_W-1:0];
        cnt      <= (reqCount <= CW'(1)) ? CW'(1) : reqCount;
        followOp <= reqFollow;
      end
    end else begin
      case (phase)
        PH_CAPT, PH_REPLAY: begin
          if (passEnd) begin
            idx <= '0;
            if (cnt <= CW'(1)) begin
              cnt   <= '0;
              phase <= PH_FOLLOW;
            end else begin
              cnt   <= cnt - CW'(1);
              phase <= PH_REPLAY;
            end
          end else if (step) begin
            idx <= idx + IDX_W'(1);
          end
        end
        PH_FOLLOW: if (!hold) phase <= PH_IDLE;
        default: ;
      endcase
    end
  end

  assign fetchReq  = (phase == PH_CAPT) && !hold;
  assign stb.capWr = (phase == PH_CAPT) && fetchValid && !hold;

  always_comb begin
    stb.src = SRC_NONE;
    if (!hold) begin
      case (phase)
        PH_CAPT:   if (fetchValid) stb.src = SRC_FETCH;
        PH_REPLAY: stb.src = SRC_ENTRY;
        PH_FOLLOW: stb.src = SRC_FOLLOW;
        default:   stb.src = SRC_NONE;
      endcase
    end
  end

  always_comb begin
    regRdata = '0;
    case (regSel)
      SEL_COUNT:  regRdata[CW-1:0] = cnt;
      SEL_STATE: begin
        regRdata[1:0]              = phase;
        regRdata[ST_IDX +: IDX_W]  = idx;
        regRdata[ST_LEN +: IDX_W]  = lenReg;
      end
      SEL_FOLLOW: regRdata = followOp;
      default:    regRdata = '0;
    endcase
  end
endmodule

// File: rtl/zol_cache_data.sv
module zol_cache_data
  import zol_cache_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int IW    = 32,
  localparam int IDX_W = $clog2(DEPTH + 1),
  localparam int EW    = IW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [IDX_W-1:0] idx,
  input  logic [IW-1:0]    fetchInstr,
  input  logic             fetchIs32,
  input  logic [IW-1:0]    followOp,
  input  logic             memWe,
  input  logic [IDX_W-1:0] memAddr,
  input  logic [EW-1:0]    memWdata,
  output logic [EW-1:0]    memRdata,
  output logic             issueValid,
  output logic [IW-1:0]    issueInstr,
  output logic             issueIs32,
  output logic             issueFollow
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [EW-1:0] entryQ [DEPTH];
  logic [EW-1:0] replayWord;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic [EW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN)
        q <= '0;
      else if (stb.capWr && (idx == IDX_W'(g)))
        q <= {fetchIs32, fetchInstr};
      else if (memWe && (memAddr == IDX_W'(g)))
        q <= memWdata;
    end
    assign entryQ[g] = q;
  end

  assign memRdata   = (memAddr <= LAST) ? entryQ[memAddr] : '0;
  assign replayWord = (idx <= LAST) ? entryQ[idx] : '0;

  always_comb begin
    issueValid  = 1'b0;
    issueInstr  = '0;
    issueIs32   = 1'b0;
    issueFollow = 1'b0;
    case (stb.src)
      SRC_FETCH: begin
        issueValid = 1'b1;
        issueInstr = fetchInstr;
        issueIs32  = fetchIs32;
      end
      SRC_ENTRY: begin
        issueValid = 1'b1;
        issueInstr = replayWord[IW-1:0];
        issueIs32  = replayWord[IW];
      end
      SRC_FOLLOW: begin
        issueValid  = 1'b1;
        issueInstr  = followOp;
        issueIs32   = 1'b1;
        issueFollow = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/zol_cache.sv
module zol_cache
  import zol_cache_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int IW    = 32,
  parameter int CW    = 16,
  localparam int IDX_W = $clog2(DEPTH + 1),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loopStart,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [CW-1:0]    reqCount,
  input  logic [IW-1:0]    reqFollow,
  input  logic             fetchValid,
  input  logic [IW-1:0]    fetchInstr,
  input  logic             fetchIs32,
  output logic             fetchReq,
  input  logic             hold,
  output logic             issueValid,
  output logic [IW-1:0]    issueInstr,
  output logic             issueIs32,
  output logic             issueFollow,
  output logic             errFlag,
  input  logic             regWe,
  input  logic [1:0]       regSel,
  input  logic [IW-1:0]    regWdata,
  output logic [IW-1:0]    regRdata,
  input  logic             memWe,
  input  logic [IDX_W-1:0] memAddr,
  input  logic [IW:0]      memWdata,
  output logic [IW:0]      memRdata
);
  strobe_t          stbW;
  logic [IDX_W-1:0] idxW;
  logic [IW-1:0]    followW;
  phase_e           phaseW;

  zol_cache_ctrl #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .loopStart(loopStart), .reqLen(reqLen),
    .reqCount(reqCount), .reqFollow(reqFollow), .fetchValid(fetchValid),
    .hold(hold), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .fetchReq(fetchReq), .errFlag(errFlag),
    .stb(stbW), .idx(idxW), .followOp(followW), .phase(phaseW)
  );

  zol_cache_data #(.DEPTH(DEPTH), .IW(IW)) u_data (
    .clk(clk), .rstN(rstN), .stb(stbW), .idx(idxW),
    .fetchInstr(fetchInstr), .fetchIs32(fetchIs32), .followOp(followW),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .issueValid(issueValid), .issueInstr(issueInstr),
    .issueIs32(issueIs32), .issueFollow(issueFollow)
  );
endmodule

// File: rtl/zol_cache_chk.sv
module zol_cache_chk
  import zol_cache_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int IDX_W = 5,
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input phase_e           phase,
  input logic [IDX_W-1:0] idx,
  input logic             loopStart,
  input logic [LEN_W-1:0] reqLen,
  input logic             fetchValid,
  input logic             fetchReq,
  input logic             hold,
  input logic             regWe,
  input logic             issueValid,
  input logic             issueFollow,
  input logic             errFlag
);
  a_r2_capture_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CAPT && !hold) |-> (fetchReq && (issueValid == fetchValid)));

  a_r3_no_fetch_in_replay: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_REPLAY) |-> !fetchReq);

  a_r4_follow_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    (issueFollow && !regWe) |=> (phase == PH_IDLE));

  a_r6_bad_len_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (loopStart && phase == PH_IDLE && !regWe &&
     (reqLen == '0 || reqLen > LEN_W'(DEPTH))) |=> (errFlag && phase == PH_IDLE));

  a_r7_hold_silent: assert property (@(posedge clk) disable iff (!rstN)
    hold |-> (!issueValid && !fetchReq));

  a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (hold && !regWe && phase == PH_REPLAY) |=> (phase == PH_REPLAY && $stable(idx)));
endmodule

bind zol_cache zol_cache_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .phase(phaseW), .idx(idxW), .loopStart(loopStart),
  .reqLen(reqLen), .fetchValid(fetchValid), .fetchReq(fetchReq), .hold(hold),
  .regWe(regWe), .issueValid(issueValid), .issueFollow(issueFollow),
  .errFlag(errFlag)
);

// File: tb/tb_zol_cache.sv
`timescale 1ns/100ps
module tb_zol_cache;
  logic        clk = 1'b0;
  logic        rstN;
  logic        loopStart;
  logic [5:0]  reqLen;
  logic [15:0] reqCount;
  logic [31:0] reqFollow;
  logic        fetchValid;
  logic [31:0] fetchInstr;
  logic        fetchIs32;
  logic        fetchReq;
  logic        hold;
  logic        issueValid;
  logic [31:0] issueInstr;
  logic        issueIs32;
  logic        issueFollow;
  logic        errFlag;
  logic        regWe;
  logic [1:0]  regSel;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic        memWe;
  logic [4:0]  memAddr;
  logic [32:0] memWdata;
  logic [32:0] memRdata;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  zol_cache dut (.*);

  // rows: {length, count}
  localparam int NV = 6;
  localparam logic [21:0] VEC [NV] = '{
    {6'd1,  16'd1}, {6'd3, 16'd0}, {6'd4, 16'd3},
    {6'd31, 16'd2}, {6'd5, 16'd1}, {6'd2, 16'd5}
  };

  function automatic logic [32:0] mk(input int tag, input int i);
    logic w;
    w = ((i + tag) % 2) == 1;
    if (w) return {1'b1, 8'hA0 | 8'(tag), 8'(i), 16'h1234 + 16'(i)};
    return {1'b0, 16'h0, 8'(tag), 8'(i)};
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic startLoop(input int len, input int cnt, input logic [31:0] fol);
    loopStart = 1'b1; reqLen = 6'(len); reqCount = 16'(cnt); reqFollow = fol;
    tick();
    loopStart = 1'b0;
  endtask

  task automatic expectIssue(input logic [32:0] w, input string req);
    #1;
    check(issueValid && !issueFollow && !fetchReq && issueInstr == w[31:0] &&
          issueIs32 == w[32], req, {issueValid, fetchReq, issueIs32, issueInstr},
          {2'b10, w});
  endtask

  task automatic expectFollow(input logic [31:0] fol, input string req);
    #1;
    check(issueValid && issueFollow && issueIs32 && issueInstr == fol, req,
          {issueFollow, issueIs32, issueInstr}, {2'b11, fol});
    tick();
    #1;
    regSel = 2'd1;
    #0.1;
    check(!issueValid && regRdata[1:0] == 2'd0, "R4 idle after follow",
          {issueValid, regRdata}, 64'd0);
    regSel = 2'd0;
  endtask

  task automatic runLoop(input int len, input int cnt, input int tag);
    int passes;
    logic [31:0] fol;
    logic [32:0] w;
    passes = (cnt <= 1) ? 1 : cnt;
    fol = 32'hF000_0000 | 32'(tag);
    regSel = 2'd0;
    startLoop(len, cnt, fol);
    #1;
    check(regRdata == 32'(passes) && !errFlag, "R10 count loaded", regRdata, passes);
    for (int i = 0; i < len; i++) begin
      w = mk(tag, i);
      fetchValid = 1'b1; fetchInstr = w[31:0]; fetchIs32 = w[32];
      #1;
      check(fetchReq && issueValid && issueInstr == w[31:0] && issueIs32 == w[32],
            "R2 capture pass-through", {fetchReq, issueValid, issueIs32, issueInstr},
            {3'b111, w});
      tick();
    end
    fetchValid = 1'b0;
    for (int p = 1; p < passes; p++) begin
      for (int i = 0; i < len; i++) begin
        if (i == 0) begin
          #1;
          check(regRdata == 32'(passes - p), "R10 count per pass", regRdata, passes - p);
        end
        expectIssue(mk(tag, i), "R3 replay order");
        tick();
      end
    end
    expectFollow(fol, (cnt <= 1) ? "R5 single pass follow" : "R4 follow-on");
    tick();
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [32:0] saved;
    logic [31:0] st;
    rstN = 1'b0; loopStart = 1'b0; reqLen = '0; reqCount = '0; reqFollow = '0;
    fetchValid = 1'b0; fetchInstr = '0; fetchIs32 = 1'b0; hold = 1'b0;
    regWe = 1'b0; regSel = 2'd0; regWdata = '0; memWe = 1'b0; memAddr = '0;
    memWdata = '0;
    repeat (3) tick();
    rstN = 1'b1;
    #1;
    check(!fetchReq && !issueValid && !issueFollow && !errFlag && regRdata == 0,
          "R1 reset idle", {fetchReq, issueValid, errFlag, regRdata}, 0);
    regSel = 2'd1;
    #0.1;
    check(regRdata == 0, "R1 state zero", regRdata, 0);
    regSel = 2'd0;
    tick();

    for (int v = 0; v < NV; v++) begin
      runLoop(int'(VEC[v][21:16]), int'(VEC[v][15:0]), v + 1);
    end

    // R6: illegal lengths
    startLoop(32, 3, 32'h0);
    #1;
    regSel = 2'd1;
    #0.1;
    check(errFlag && !fetchReq && regRdata[1:0] == 0, "R6 length 32 rejected",
          {errFlag, fetchReq, regRdata}, {1'b1, 1'b0, 32'd0});
    tick();
    startLoop(0, 3, 32'h0);
    #1;
    check(errFlag && !fetchReq && !issueValid, "R6 length 0 rejected",
          {errFlag, fetchReq}, 2'b10);
    regSel = 2'd0;
    tick();
    startLoop(2, 1, 32'hF00D_0001);
    #1;
    check(!errFlag && fetchReq, "R6 error cleared by valid start", {errFlag, fetchReq}, 2'b01);
    fetchValid = 1'b1; fetchInstr = 32'h11; fetchIs32 = 1'b0; tick();
    fetchInstr = 32'h22; tick();
    fetchValid = 1'b0;
    expectFollow(32'hF00D_0001, "R5 count 1 follow");
    tick();

    // R7/R8/R9: interrupt save and restore mid-replay
    regSel = 2'd0;
    startLoop(4, 3, 32'hF000_0009);
    for (int i = 0; i < 4; i++) begin
      fetchValid = 1'b1; fetchInstr = mk(9, i); fetchIs32 = mk(9, i) >> 32; tick();
    end
    fetchValid = 1'b0;
    expectIssue(mk(9, 0), "R3 replay before hold"); tick();
    expectIssue(mk(9, 1), "R3 replay before hold"); tick();
    hold = 1'b1;
    #1;
    check(!issueValid && !fetchReq, "R7 hold silences issue", {issueValid, fetchReq}, 0);
    repeat (3) tick();
    regSel = 2'd1;
    #1;
    st = (32'd4 << 7) | (32'd2 << 2) | 32'd2;
    check(regRdata == st, "R7 R8 frozen state word", regRdata, st);
    regSel = 2'd0;
    #0.1;
    check(regRdata == 2, "R7 R10 frozen count", regRdata, 2);
    memAddr = 5'd2;
    #0.1;
    saved = memRdata;
    check(memRdata == mk(9, 2), "R9 window read", memRdata, mk(9, 2));
    tick();
    regWe = 1'b1; regSel = 2'd1; regWdata = 32'h0;
    memWe = 1'b1; memWdata = 33'h1_DEAD_BEEF;
    tick();
    regSel = 2'd0; memWe = 1'b0;
    tick();
    regWe = 1'b0; regSel = 2'd1;
    #1;
    check(regRdata == 0 && memRdata == 33'h1_DEAD_BEEF, "R8 R9 writes land",
          {regRdata, memRdata[31:0]}, {32'd0, 32'hDEAD_BEEF});
    regSel = 2'd0;
    #0.1;
    check(regRdata == 0, "R8 count write", regRdata, 0);
    tick();
    memWe = 1'b1; memWdata = saved;
    regWe = 1'b1; regSel = 2'd0; regWdata = 32'd2;
    tick();
    memWe = 1'b0; regSel = 2'd1; regWdata = st;
    tick();
    regWe = 1'b0; regSel = 2'd0; hold = 1'b0;
    expectIssue(mk(9, 2), "R8 resume at saved index"); tick();
    expectIssue(mk(9, 3), "R3 resume continue"); tick();
    for (int i = 0; i < 4; i++) begin
      expectIssue(mk(9, i), "R3 last pass after restore"); tick();
    end
    expectFollow(32'hF000_0009, "R4 follow after restore");
    tick();
    finishRun();
  end
endmodule